// File: doc/BRIEF.md
# ACPI Power Rail Sequencer

This block is the digital controller of a memory and chipset power subsystem. It watches two power-on-reset comparators (standby bias and the 12 V bus) and two active-low sleep inputs, and brings up five regulated rails in a fixed order. Each rail reports an in-regulation flag. The block drives these outputs:

- a hold-in-reset for the error amplifiers;
- an enable and a soft-start ramp request for each ramped rail;
- a reference-short control for the memory termination regulator;
- a power-good output and a fault flag.

Rail indices are fixed:

- 0: memory core
- 1: chipset core
- 2: CPU/chipset termination
- 3: DAC
- 4: memory termination

Once power and both sleep inputs are valid, the amplifiers are held in reset for three soft-start periods. After that, each stage is enabled only when the previous stage reports regulation. The memory termination rail has no ramp. Its reference is shorted to its output while it is off, and the short is released when the rail is enabled.

A low on the sleep-to-RAM input keeps only the memory core alive. A low on the soft-off input, or a loss of either power-on-reset input, shuts everything down and restarts the whole sequence. All control and status pins are plain levels. The block has no data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pwr_rail_seq`

## Requirements
- R1: After reset, and until `sby_ok`, `p12_ok`, `slp3_n` and `slp5_n` are all high, `rail_en` is 0, `amp_hold` is 0, `ramp_req` is 0 and `ref_short` is 1.
- R2: When the start conditions hold, `amp_hold` is high for exactly 3*SS_CYC consecutive cycles with `rail_en` at 0. In the first cycle after it falls, only `rail_en[0]` is set.
- R3: `ramp_req[i]` (i = 0..3) rises with `rail_en[i]`. It stays high for SS_CYC cycles, or until the stage advances, and is never high while `rail_en[i]` is low.
- R4: `rail_en[1]` is set only after rail 0's in-regulation flag has qualified.
- R5: `rail_en[2]` and `rail_en[3]` are always equal, and they are set only after rail 1 qualifies.
- R6: `rail_en[4]` is set only after both rails 2 and 3 qualify. `ref_short` is 0 exactly when `rail_en[4]` is 1.
- R7: An in-regulation flag qualifies only after it has been high for STABLE_CYC consecutive cycles. A shorter pulse does not advance the sequence.
- R8: `pgood` is 1 only in the fully-on state and only while rail 2 is qualified. It falls within two cycles of rail 2's flag dropping.
- R9: If `sby_ok` or `p12_ok` falls, all outputs return to the R1 state within three cycles. On recovery, the full sequence restarts, including the 3*SS_CYC hold.
- R10: `slp3_n` low, once at least rail 0 is on, leaves `rail_en` = 5'b00001 with `ref_short` = 1. When `slp3_n` returns high, the sequence resumes from rail 1 and ends with all five rails on.
- R11: `slp5_n` low turns every rail off, sets `ref_short` and clears `fault`.
- R12: If a ramping stage's rails do not qualify within TMO_CYC cycles of that stage starting, `fault` goes high and the sequence stops advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sby_ok | input | 1 | Standby bias above its POR threshold (asynchronous) |
| p12_ok | input | 1 | 12 V bus above its POR threshold (asynchronous) |
| slp3_n | input | 1 | Active-low sleep-to-RAM request (asynchronous) |
| slp5_n | input | 1 | Active-low soft-off request (asynchronous) |
| rail_good | input | 5 | Per-rail in-regulation flags |
| amp_hold | output | 1 | Holds the error amplifiers in reset |
| rail_en | output | 5 | Per-rail enable |
| ramp_req | output | 4 | Soft-start ramp request for rails 0 to 3 |
| ref_short | output | 1 | Shorts the memory termination reference to its output |
| pgood | output | 1 | Termination power-good |
| fault | output | 1 | Start-up timeout seen |

## Verification
The checker examines several relations on every cycle:

- no enable is set during the amplifier hold;
- the two termination-stage enables always match;
- the reference short is the exact complement of the memory termination enable;
- a ramp request never appears without its rail's enable;
- the chipset rail's enable rises only after the memory core flag was high;
- power-good never leads its rail's flag.

Only the bench's scenarios can show the remaining behaviours:

- the exact hold and ramp lengths;
- that a short regulation glitch does not advance the sequence;
- the sleep and power-loss recovery paths;
- the timeout fault.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NRAIL = 5;
  localparam int NRAMP = 4;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_HOLD,
    ST_MEM,
    ST_CHIP,
    ST_TERM,
    ST_RUN,
    ST_SLEEP
  } seq_state_t;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/pwrseq_qual.sv
module pwrseq_qual #(
  parameter int N          = 5,
  parameter int STABLE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] ok
);
  localparam int QW = $clog2(STABLE_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(STABLE_CYC);

  for (genvar i = 0; i < N; i++) begin : g_rail
    logic [QW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run <= '0;
      else if (!raw[i])      run <= '0;
      else if (run != QMAX)  run <= run + 1'b1;
    end
    assign ok[i] = (run == QMAX);
  end
endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
  import pwrseq_pkg::*;
#(
  parameter int SS_CYC     = 2050000,
  parameter int STABLE_CYC = 250,
  parameter int TMO_CYC    = 8200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sby_ok,
  input  logic       p12_ok,
  input  logic       slp3_n,
  input  logic       slp5_n,
  input  logic [4:0] rail_good,
  output logic       amp_hold,
  output logic [4:0] rail_en,
  output logic [3:0] ramp_req,
  output logic       ref_short,
  output logic       pgood,
  output logic       fault
);
  localparam int HOLD_CYC = 3 * SS_CYC;
  localparam int CNT_MAX  = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] C_HOLD_END = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] C_TMO_END  = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] C_SS       = CW'(SS_CYC);
  localparam logic [CW-1:0] C_MAX      = CW'(CNT_MAX);

  logic [3:0]       sync_q;
  logic             sby_s, p12_s, slp3_s, slp5_s;
  logic [NRAIL-1:0] good_q;

  pwrseq_sync #(.W(4)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({slp5_n, slp3_n, p12_ok, sby_ok}),
    .q    (sync_q)
  );
  assign {slp5_s, slp3_s, p12_s, sby_s} = sync_q;

  pwrseq_qual #(.N(NRAIL), .STABLE_CYC(STABLE_CYC)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (rail_good),
    .ok   (good_q)
  );

  seq_state_t    st, nxt;
  logic [CW-1:0] cnt;
  logic          fault_r;
  logic          ramping;

  assign ramping = (st == ST_MEM) || (st == ST_CHIP) || (st == ST_TERM);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_OFF:   if (slp3_s) nxt = ST_HOLD;
      ST_HOLD:  if (cnt == C_HOLD_END) nxt = ST_MEM;
      ST_MEM:   if (!fault_r && good_q[0]) nxt = ST_CHIP;
      ST_CHIP:  if (!fault_r && good_q[1]) nxt = ST_TERM;
      ST_TERM:  if (!fault_r && good_q[2] && good_q[3]) nxt = ST_RUN;
      ST_RUN:   nxt = ST_RUN;
      ST_SLEEP: if (slp3_s) nxt = good_q[0] ? ST_CHIP : ST_MEM;
      default:  nxt = ST_OFF;
    endcase
    if (!(sby_s && p12_s && slp5_s)) begin
      nxt = ST_OFF;
    end else if (!slp3_s) begin
      if (st == ST_HOLD) nxt = ST_OFF;
      else if (st != ST_OFF) nxt = ST_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      cnt     <= '0;
      fault_r <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st)        cnt <= '0;
      else if (cnt != C_MAX) cnt <= cnt + 1'b1;
      if (nxt == ST_OFF)
        fault_r <= 1'b0;
      else if (ramping && nxt == st && cnt == C_TMO_END)
        fault_r <= 1'b1;
    end
  end

  always_comb begin
    rail_en  = 5'b00000;
    ramp_req = 4'b0000;
    unique case (st)
      ST_MEM:   begin rail_en = 5'b00001; ramp_req[0]   = (cnt < C_SS); end
      ST_CHIP:  begin rail_en = 5'b00011; ramp_req[1]   = (cnt < C_SS); end
      ST_TERM:  begin rail_en = 5'b01111; ramp_req[3:2] = {2{cnt < C_SS}}; end
      ST_RUN:   rail_en = 5'b11111;
      ST_SLEEP: rail_en = 5'b00001;
      default:  rail_en = 5'b00000;
    endcase
  end

  assign amp_hold  = (st == ST_HOLD);
  assign ref_short = (st != ST_RUN);
  assign pgood     = (st == ST_RUN) && good_q[2];
  assign fault     = fault_r;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       amp_hold,
  input logic [4:0] rail_en,
  input logic [3:0] ramp_req,
  input logic       ref_short,
  input logic       pgood,
  input logic [4:0] rail_good
);
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    amp_hold |-> rail_en == 5'b00000); // R2
  AST_RAMP_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_req & ~rail_en[3:0]) == 4'b0000); // R3
  AST_CHIP_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[1]) |-> $past(rail_good[0])); // R4
  AST_TERM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en[2] == rail_en[3]); // R5
  AST_SHORT_VS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ref_short == !rail_en[4]); // R6
  AST_PGOOD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> ($past(rail_good[2]) && rail_en[4])); // R8
endmodule

bind pwr_rail_seq pwrseq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .amp_hold (amp_hold),
  .rail_en  (rail_en),
  .ramp_req (ramp_req),
  .ref_short(ref_short),
  .pgood    (pgood),
  .rail_good(rail_good)
);

// File: tb/pwr_rail_seq_test.sv
module pwr_rail_seq_test;
  localparam int SS = 16;
  localparam int STB = 4;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sby_ok = 1'b0, p12_ok = 1'b0, slp3_n = 1'b0, slp5_n = 1'b0;
  logic [4:0] rail_good = '0;
  logic amp_hold, ref_short, pgood, fault;
  logic [4:0] rail_en;
  logic [3:0] ramp_req;

  always #2 clk = ~clk;

  pwr_rail_seq #(.SS_CYC(SS), .STABLE_CYC(STB), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .sby_ok(sby_ok), .p12_ok(p12_ok),
    .slp3_n(slp3_n), .slp5_n(slp5_n), .rail_good(rail_good),
    .amp_hold(amp_hold), .rail_en(rail_en), .ramp_req(ramp_req),
    .ref_short(ref_short), .pgood(pgood), .fault(fault)
  );

  // flags = {ramp_req[3:0], amp_hold, ref_short, pgood, fault}
  typedef struct {
    string      tag;
    logic [4:0] en;
    logic [7:0] flags;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic push_exp(input string tag, input logic [4:0] en, input logic [7:0] flags);
    exp_t e;
    e.tag = tag; e.en = en; e.flags = flags;
    exp_q.push_back(e);
  endtask

  task automatic chk_int(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] f;
        e = exp_q.pop_front();
        f = {ramp_req, amp_hold, ref_short, pgood, fault};
        n_chk++;
        if (rail_en !== e.en || f !== e.flags) begin
          n_bad++;
          $display("FAIL %s actual en=%b flags=%b expected en=%b flags=%b",
                   e.tag, rail_en, f, e.en, e.flags);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_hold_len(input string tag);
    int len;
    int g;
    g = 0;
    while (!amp_hold && g < 500) begin @(negedge clk); g++; end
    len = 0;
    while (amp_hold && len < 500) begin @(negedge clk); len++; end
    chk_int(tag, len, 3 * SS);
  endtask

  task automatic wait_en(input int bitn);
    int g;
    g = 0;
    while (!rail_en[bitn] && g < 200) begin @(negedge clk); g++; end
  endtask

  initial begin : watchdog
    repeat (20000) @(negedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int n;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    push_exp("R1 reset state", 5'b00000, 8'b0000_0100);

    sby_ok = 1; p12_ok = 1; slp5_n = 1; slp3_n = 0;
    cyc(10);
    push_exp("R1 waits for slp3_n", 5'b00000, 8'b0000_0100);

    slp3_n = 1;
    wait_hold_len("R2 hold length");
    push_exp("R2 R3 memory core first", 5'b00001, 8'b0001_0100);
    n = 0;
    while (ramp_req[0] && n < 200) begin @(negedge clk); n++; end
    chk_int("R3 ramp length", n, SS);

    rail_good[0] = 1; cyc(2); rail_good[0] = 0; cyc(6);
    push_exp("R7 R4 glitch ignored", 5'b00001, 8'b0000_0100);

    rail_good[0] = 1;
    wait_en(1);
    push_exp("R4 chipset after memory core", 5'b00011, 8'b0010_0100);
    cyc(20);
    push_exp("R5 waits for chipset good", 5'b00011, 8'b0000_0100);

    rail_good[1] = 1;
    wait_en(2);
    push_exp("R5 R3 term and DAC together", 5'b01111, 8'b1100_0100);

    rail_good[2] = 1; rail_good[3] = 1;
    wait_en(4);
    push_exp("R6 R8 memory termination last", 5'b11111, 8'b0000_0010);

    rail_good[2] = 0; cyc(2);
    push_exp("R8 pgood drops", 5'b11111, 8'b0000_0000);
    rail_good[2] = 1; cyc(8);
    push_exp("R8 pgood back", 5'b11111, 8'b0000_0010);

    slp3_n = 0; cyc(4);
    push_exp("R10 sleep keeps memory core", 5'b00001, 8'b0000_0100);
    slp3_n = 1; cyc(10);
    push_exp("R10 resume all on", 5'b11111, 8'b0000_0010);

    p12_ok = 0; cyc(4);
    push_exp("R9 POR loss all off", 5'b00000, 8'b0000_0100);
    p12_ok = 1;
    wait_hold_len("R9 hold repeats");
    cyc(10);
    push_exp("R9 resequenced", 5'b11111, 8'b0000_0010);

    rail_good = '0;
    p12_ok = 0; cyc(4); p12_ok = 1;
    wait_hold_len("R12 hold before fault");
    cyc(TMO + 16);
    push_exp("R12 timeout fault", 5'b00001, 8'b0000_0101);
    rail_good = 5'b11111; cyc(10);
    push_exp("R12 stops advancing", 5'b00001, 8'b0000_0101);

    slp5_n = 0; cyc(4);
    push_exp("R11 soft-off clears", 5'b00000, 8'b0000_0100);

    cyc(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule